// File: doc/BRIEF.md
# Serial-Controlled Sixteen-Channel Switch Controller

This block is the digital control section of a sixteen-channel low-side switch. A host talks to it over a 24-bit SPI-style slave port. Each frame does two things at once. It carries an on/off command for every channel into the block. It also returns a fault report that the block captures at the moment chip-select falls.

All pin inputs are brought into the system clock domain through synchronizer chains. Serial clock and chip-select edges are then detected there, so the system clock must run at least four times faster than the serial clock.

An over-voltage detector input goes through a debounce counter before it can turn every channel off. A retry bit in the command decides what happens once the condition clears. With retry set, the channels come back to their programmed state. With retry clear, they stay dark until the next accepted command.

Top module: `lsd16_ctrl`

## Requirements
- R1: A frame is 24 bits, shifted most significant bit first. On acceptance, command bit i (for i in 0..15) sets the enable of channel i (1 = on), bit 16 is the retry flag, and bits 23..17 are ignored.
- R2: `spi_mosi` is captured on each falling edge of `spi_sclk`. `spi_miso` updates on each rising edge, and the first rising edge of a frame presents status bit 23.
- R3: On the falling edge of `spi_cs_n`, a status word is captured for transmission. Bit 23 is the OR of all fault sources, bit 22 is the over-voltage flag, bits 21..16 are 0, and bit i (0..15) is 1 when `ch_fault[i]` is 1.
- R4: A command is applied only when `spi_cs_n` rises after exactly 24 falling serial clock edges. Any other count leaves the channel outputs and the retry flag unchanged.
- R5: While `spi_cs_n` is high, `spi_miso_oe` is 0, and activity on `spi_sclk` and `spi_mosi` has no effect on the channels or on the next frame.
- R6: When `ov_det` stays high for `OV_FILT_CYCLES` consecutive system clocks, all channel outputs go to 0. A shorter pulse has no effect on the outputs.
- R7: When `ov_det` falls after a shutdown, the channels return to their enabled state if the retry flag is 1. If the retry flag is 0, they stay off until the next accepted command.
- R8: After a shutdown, status bits 23 and 22 read 1 in the next frame. After that frame has reported the shutdown, and once the condition is gone, the bits return to 0.
- R9: While `rst_n` is low, all channel outputs and `spi_miso_oe` are 0. Afterwards, enables, retry flag and all flags are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from host (asynchronous) |
| spi_cs_n | input | 1 | Active-low chip-select from host (asynchronous) |
| spi_mosi | input | 1 | Serial command data from host |
| spi_miso | output | 1 | Serial status data to host |
| spi_miso_oe | output | 1 | Output enable for the `spi_miso` pad driver |
| ch_fault | input | 16 | Per-channel fault flags, system clock domain |
| ov_det | input | 1 | Raw over-voltage indication, system clock domain |
| ch_on | output | 16 | Per-channel switch drive, 1 = on |

## Verification
The assertions assume a host that respects the SPI contract:
- The serial clock is low whenever chip-select changes.
- No serial clock edge lands in the same system clock cycle as a chip-select edge.
- Each serial clock phase lasts at least two system clocks.

The stimulus holds every serial clock phase for six system clocks. It waits eight clocks after lowering chip-select before the first rising edge, and six clocks after the last falling edge before raising it. It drives the over-voltage and fault inputs only between frames, so that each status capture sees settled values.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
   localparam int unsigned FRAME_W = 24;
   localparam int unsigned CH_N    = 16;
   localparam int unsigned PAD_W   = FRAME_W - CH_N - 2;
   localparam int unsigned CNT_W   = $clog2(FRAME_W) + 1;
   localparam int unsigned RETRY_BIT = CH_N;

   typedef struct packed {
      logic             any_flt;
      logic             ov_flt;
      logic [PAD_W-1:0] zeros;
      logic [CH_N-1:0]  ch_flt;
   } status_t;
endpackage

// File: rtl/lsd_pin_sync.sv
module lsd_pin_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned W      = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("lsd_pin_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= din;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/lsd_frame_engine.sv
module lsd_frame_engine
   import lsd_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk_s,
   input  logic               cs_n_s,
   input  logic               mosi_s,
   input  logic [FRAME_W-1:0] status,
   output logic               frame_start,
   output logic               cmd_valid,
   output logic [FRAME_W-1:0] cmd_word,
   output logic               miso,
   output logic               miso_oe
);
   logic               sclk_d, cs_d;
   logic               sclk_rise, sclk_fall, cs_fall, cs_rise, sel;
   logic [FRAME_W-1:0] rx_sr, tx_sr;
   logic [CNT_W-1:0]   bit_cnt;
   logic               miso_q;

   assign sclk_rise = sclk_s & ~sclk_d;
   assign sclk_fall = ~sclk_s & sclk_d;
   assign cs_fall   = cs_d & ~cs_n_s;
   assign cs_rise   = ~cs_d & cs_n_s;
   assign sel       = ~cs_n_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d    <= 1'b0;
         cs_d      <= 1'b1;
         rx_sr     <= '0;
         tx_sr     <= '0;
         bit_cnt   <= '0;
         miso_q    <= 1'b0;
         cmd_word  <= '0;
         cmd_valid <= 1'b0;
      end else begin
         sclk_d    <= sclk_s;
         cs_d      <= cs_n_s;
         cmd_valid <= 1'b0;
         if (cs_fall) begin
            tx_sr   <= status;
            rx_sr   <= '0;
            bit_cnt <= '0;
            miso_q  <= 1'b0;
         end else if (sel) begin
            if (sclk_fall) begin
               rx_sr <= {rx_sr[FRAME_W-2:0], mosi_s};
               if (bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
            end
            if (sclk_rise) begin
               miso_q <= tx_sr[FRAME_W-1];
               tx_sr  <= {tx_sr[FRAME_W-2:0], 1'b0};
            end
         end
         if (cs_rise && bit_cnt == CNT_W'(FRAME_W)) begin
            cmd_word  <= rx_sr;
            cmd_valid <= 1'b1;
         end
      end
   end

   assign frame_start = cs_fall;
   assign miso        = miso_q;
   assign miso_oe     = sel;

   AST_MISO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !sclk_rise && !cs_fall) |=> $stable(miso_q)); // R2
   AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |=> $stable(bit_cnt)); // R5
   AST_ONE_CMD_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid); // R4
endmodule

// File: rtl/lsd_ov_filter.sv
module lsd_ov_filter #(
   parameter int unsigned LIMIT = 6250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ov_in,
   output logic shut
);
   localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);

   if (LIMIT < 1) begin : g_bad_limit
      $error("lsd_ov_filter: LIMIT must be at least 1");
   end

   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
         shut    <= 1'b0;
      end else if (!ov_in) begin
         run_cnt <= '0;
         shut    <= 1'b0;
      end else if (!shut) begin
         if (run_cnt == CW'(LIMIT - 1)) shut <= 1'b1;
         else                           run_cnt <= run_cnt + 1'b1;
      end
   end

   AST_SHUT_NEEDS_OV: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shut) |-> $past(ov_in)); // R6
   AST_SHUT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      !ov_in |=> !shut); // R7
endmodule

// File: rtl/lsd16_ctrl.sv
module lsd16_ctrl
   import lsd_pkg::*;
#(
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned OV_FILT_CYCLES = 6250
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            spi_sclk,
   input  logic            spi_cs_n,
   input  logic            spi_mosi,
   output logic            spi_miso,
   output logic            spi_miso_oe,
   input  logic [CH_N-1:0] ch_fault,
   input  logic            ov_det,
   output logic [CH_N-1:0] ch_on
);
   if (FRAME_W < CH_N + 3) begin : g_bad_frame
      $error("lsd16_ctrl: frame too short for status layout");
   end

   logic [2:0]         pins_s;
   logic               sclk_s, cs_n_s, mosi_s;
   logic               frame_start, cmd_valid;
   logic [FRAME_W-1:0] cmd_word;
   logic               ov_shut;
   logic [CH_N-1:0]    en_q;
   logic               retry_q, hold_off, ov_seen, all_off;
   status_t            stat;
   logic               unused_hi;

   lsd_pin_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b010)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .din({spi_sclk, spi_cs_n, spi_mosi}),
      .dout(pins_s)
   );
   assign {sclk_s, cs_n_s, mosi_s} = pins_s;

   always_comb begin
      stat.ov_flt  = ov_seen | ov_shut;
      stat.any_flt = stat.ov_flt | (|ch_fault);
      stat.zeros   = '0;
      stat.ch_flt  = ch_fault;
   end

   lsd_frame_engine u_eng (
      .clk(clk), .rst_n(rst_n),
      .sclk_s(sclk_s), .cs_n_s(cs_n_s), .mosi_s(mosi_s),
      .status(stat),
      .frame_start(frame_start), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
      .miso(spi_miso), .miso_oe(spi_miso_oe)
   );

   lsd_ov_filter #(.LIMIT(OV_FILT_CYCLES)) u_ovf (
      .clk(clk), .rst_n(rst_n), .ov_in(ov_det), .shut(ov_shut)
   );

   assign unused_hi = ^cmd_word[FRAME_W-1:RETRY_BIT+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= '0;
         retry_q  <= 1'b0;
         hold_off <= 1'b0;
         ov_seen  <= 1'b0;
      end else begin
         if (cmd_valid) begin
            en_q     <= cmd_word[CH_N-1:0];
            retry_q  <= cmd_word[RETRY_BIT];
            hold_off <= 1'b0;
         end
         if (ov_shut && !retry_q) hold_off <= 1'b1;
         if (ov_shut)          ov_seen <= 1'b1;
         else if (frame_start) ov_seen <= 1'b0;
      end
   end

   assign all_off = ov_shut | hold_off;

   for (genvar i = 0; i < CH_N; i++) begin : g_ch
      assign ch_on[i] = en_q[i] & ~all_off;
   end

   AST_OFF_IN_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
      ov_shut |-> (ch_on == '0)); // R6
   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> ($stable(en_q) && $stable(retry_q))); // R4
   AST_FLAG_AFTER_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ov_shut) |-> ov_seen); // R8
endmodule

// File: tb/sim_lsd16_ctrl.sv
module sim_lsd16_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   logic        miso, miso_oe;
   logic [15:0] flt = '0;
   logic        ov = 1'b0;
   logic [15:0] ch_on;
   int          n_vec = 0, n_bad = 0;

   always #4 clk = ~clk;

   lsd16_ctrl #(.SYNC_STAGES(2), .OV_FILT_CYCLES(20)) u0 (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
      .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe),
      .ch_fault(flt), .ov_det(ov), .ch_on(ch_on)
   );

   typedef struct packed {
      logic [23:0] cmd;
      logic [4:0]  nclk;
      logic [15:0] flt;
      logic [15:0] exp_on;
      logic [23:0] exp_stat;
   } vec_t;

   localparam vec_t VT [6] = '{
      '{24'h00A5A5, 5'd24, 16'h0000, 16'hA5A5, 24'h000000},
      '{24'h01FFFF, 5'd24, 16'h0001, 16'hFFFF, 24'h800001},
      '{24'h001234, 5'd23, 16'h8000, 16'hFFFF, 24'h808000},
      '{24'h00F00F, 5'd25, 16'h0000, 16'hFFFF, 24'h000000},
      '{24'hFE0F0F, 5'd24, 16'h0000, 16'h0F0F, 24'h000000},
      '{24'h013C3C, 5'd24, 16'h0300, 16'h3C3C, 24'h800300}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic frame(input logic [23:0] cmd, input int nclk, output logic [23:0] got);
      got = '0;
      cs_n = 1'b0;
      repeat (8) @(negedge clk);
      chk("R5 oe while selected", {31'd0, miso_oe}, 32'd1);
      for (int i = 0; i < nclk; i++) begin
         mosi = (i < 24) ? cmd[23-i] : 1'b0;
         sclk = 1'b1;
         repeat (6) @(negedge clk);
         if (i < 24) got = {got[22:0], miso};
         sclk = 1'b0;
         repeat (6) @(negedge clk);
      end
      cs_n = 1'b1;
      repeat (10) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [23:0] got;
      int m;
      repeat (3) @(negedge clk);
      chk("R9 reset ch_on", {16'd0, ch_on}, 32'd0);
      chk("R9 reset oe", {31'd0, miso_oe}, 32'd0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R5 oe idle", {31'd0, miso_oe}, 32'd0);

      // R1 R2 R3 R4: vector table
      for (int v = 0; v < 6; v++) begin
         flt = VT[v].flt;
         @(negedge clk);
         frame(VT[v].cmd, int'(VT[v].nclk), got);
         m = (VT[v].nclk < 24) ? int'(VT[v].nclk) : 24;
         chk("R3 status word", {8'd0, got}, {8'd0, VT[v].exp_stat >> (24 - m)});
         chk("R1 R4 channel outputs", {16'd0, ch_on}, {16'd0, VT[v].exp_on});
      end
      flt = '0;

      // R5: stray clocks while deselected
      for (int i = 0; i < 30; i++) begin
         mosi = i[0]; sclk = 1'b1; repeat (3) @(negedge clk);
         sclk = 1'b0; repeat (3) @(negedge clk);
      end
      chk("R5 ch_on untouched", {16'd0, ch_on}, 32'h3C3C);
      chk("R5 oe deselected", {31'd0, miso_oe}, 32'd0);

      // R6 R7 with retry set
      ov = 1'b1; repeat (25) @(negedge clk);
      chk("R6 shutdown", {16'd0, ch_on}, 32'd0);
      ov = 1'b0; repeat (4) @(negedge clk);
      chk("R7 retry restore", {16'd0, ch_on}, 32'h3C3C);
      frame(24'h000081, 24, got);
      chk("R8 flags after shutdown", {8'd0, got}, 32'hC00000);
      chk("R1 new enables", {16'd0, ch_on}, 32'h0081);
      frame(24'h000081, 24, got);
      chk("R8 flags cleared", {8'd0, got}, 32'h000000);

      // R6 short pulse
      ov = 1'b1; repeat (15) @(negedge clk);
      ov = 1'b0; repeat (4) @(negedge clk);
      chk("R6 short pulse ignored", {16'd0, ch_on}, 32'h0081);

      // R7 without retry
      ov = 1'b1; repeat (25) @(negedge clk);
      ov = 1'b0; repeat (10) @(negedge clk);
      chk("R7 stays off", {16'd0, ch_on}, 32'd0);
      frame(24'h000042, 24, got);
      chk("R8 flags no retry", {8'd0, got}, 32'hC00000);
      chk("R7 released by command", {16'd0, ch_on}, 32'h0042);

      // R9 reset in operation
      rst_n = 1'b0; repeat (3) @(negedge clk);
      chk("R9 reset clears outputs", {16'd0, ch_on}, 32'd0);
      chk("R9 reset oe", {31'd0, miso_oe}, 32'd0);
      rst_n = 1'b1; repeat (4) @(negedge clk);
      frame(24'h000000, 24, got);
      chk("R9 flags cleared", {8'd0, got}, 32'd0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule